// File: doc/BRIEF.md
# Serial Register Access Slave

This block gives an external controller read and write access to a bank of 128 eight-bit control registers over four wires: an active-low select, a serial clock, a serial data input and a serial data output. Every access is a 16-bit frame. The first seven bits give the register address, least significant bit first. The eighth bit gives the direction. The last eight bits carry the data, least significant bit first. The controller shifts data in on the rising clock edge. For a read, the block shifts the register value out on the falling edges that come between those rising edges.

The select, clock and data pins are passed through a synchroniser into the system clock domain, and the clock edges are detected there, so the whole block runs on one internal clock. The serial clock must therefore be several system clocks long per phase. The output pin is a data bit `sdo` plus an enable `sdo_oe`. When the enable is low the pad is high impedance, so other devices can share the lines. A write reaches the register only on the sixteenth rising edge of its frame. If select rises before that edge, the frame is aborted, nothing is written, and the bit count starts again at zero.

The frame controller is a four-state machine:
- ST_IDLE: select is inactive.
- ST_ADDR: the address and direction bits are being collected.
- ST_WDATA: write data is coming in.
- ST_RDATA: read data is going out.

It moves between these states as follows:
- IDLE→ADDR when select goes active.
- ADDR→WDATA on the direction-bit rising edge when that bit is 0.
- ADDR→RDATA on the direction-bit rising edge when that bit is 1.
- WDATA→ADDR or RDATA→ADDR on the sixteenth rising edge, which ends the frame.
- Any state→IDLE when select goes inactive.

Top module: `sreg_slave`

## Requirements
- R1: After reset all 128 registers read as 0x00 and `sdo_oe` is low.
- R2: A frame is bits 0–6 = address (A0 first), bit 7 = direction (0 write, 1 read), bits 8–15 = data (D0 first); each bit is sampled on a rising serial clock edge.
- R3: Write data is stored in the addressed register on the 16th rising edge of the frame and at no earlier edge; each commit lasts one system clock.
- R4: In a read frame, D0 appears on `sdo` after the falling edge that follows the direction bit, and each later bit appears after the next falling edge; `sdo` holds steady between falling edges.
- R5: `sdo_oe` is high only while select is low and a read frame is in its 8-bit data window; it is low during address phases and during write frames.
- R6: Frames may follow one another while select stays low; the bit count wraps after 16 bits and the next address phase starts with no select toggle.
- R7: Raising select mid-frame aborts it: an uncommitted write is discarded, `sdo_oe` goes low, and the next frame after select falls again is aligned from bit 0.
- R8: Clock and data activity while select is high has no effect on any register.
- R9: While `rst_n` is low, all serial activity is ignored and `sdo_oe` stays low.
- R10: A read leaves the register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cs_n | input | 1 | Active-low select from the controller |
| sclk | input | 1 | Serial clock from the controller |
| sdi | input | 1 | Serial data in: address, direction, write data |
| sdo | output | 1 | Serial read data out |
| sdo_oe | output | 1 | Output enable for the sdo pad; low means high impedance |

## Verification
The bench builds the block with its default parameters: a 7-bit address, 8-bit data and a two-stage synchroniser. With a 128-entry bank, the bench can sweep the whole address space. It writes a distinct arithmetic pattern to every register in back-to-back frames under one select. It then reads every register back the same way and checks the output enable at every bit slot. On this small configuration the bench also aborts a write at its fifteenth edge and aborts a read in the middle of its data window. It sends a whole frame with select high, and it drives a frame while reset is held. After each of these it checks the register contents through ordinary reads.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_WDATA = 2'd2,
        ST_RDATA = 2'd3
    } sreg_state_e;

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe[i] <= RST_VAL;
            end
        end else begin
            pipe[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/sreg_fsm.sv
module sreg_fsm
    import sreg_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              rise_o,
    output logic              fall_o
);

    localparam int FRAME = ADDR_W + 1 + DATA_W;
    localparam int CNT_W = $clog2(FRAME);
    localparam logic [CNT_W-1:0] DIR_CNT  = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME - 1);

    sreg_state_e       state, state_d;
    logic [CNT_W-1:0]  cnt;
    logic              sclk_q;
    logic              rise, fall;
    logic [ADDR_W-1:0] addr_sh;
    logic [DATA_W-1:0] wdat_sh;
    logic [DATA_W-1:0] rdat_sh;
    logic              drive_q;
    logic              sdo_q;
    logic              wr_en_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [DATA_W-1:0] wr_data_q;

    // Edge detection in the system domain, gated by select.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_i;
    end

    assign rise = sel_i &&  sclk_i && !sclk_q;
    assign fall = sel_i && !sclk_i &&  sclk_q;

    // Next-state logic.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (sel_i) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (!sel_i)                      state_d = ST_IDLE;
                else if (rise && cnt == DIR_CNT) state_d = sdi_i ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA, ST_RDATA: begin
                if (!sel_i)                       state_d = ST_IDLE;
                else if (rise && cnt == LAST_CNT) state_d = ST_ADDR;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Bit counter and shift registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            addr_sh <= '0;
            wdat_sh <= '0;
            rdat_sh <= '0;
        end else if (!sel_i) begin
            cnt <= '0;
        end else begin
            if (rise) begin
                cnt <= (cnt == LAST_CNT) ? '0 : cnt + 1'b1;
                if (state == ST_ADDR && cnt < DIR_CNT) begin
                    addr_sh <= {sdi_i, addr_sh[ADDR_W-1:1]};
                end
                if (state == ST_ADDR && cnt == DIR_CNT && sdi_i) begin
                    rdat_sh <= rd_data_i;
                end
                if (state == ST_WDATA) begin
                    wdat_sh <= {sdi_i, wdat_sh[DATA_W-1:1]};
                end
            end
            if (fall && state == ST_RDATA) begin
                rdat_sh <= rdat_sh >> 1;
            end
        end
    end

    // Output process: commit strobe, read data and pad enable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
            drive_q   <= 1'b0;
            sdo_q     <= 1'b0;
        end else begin
            wr_en_q <= 1'b0;
            if (state == ST_WDATA && rise && cnt == LAST_CNT) begin
                wr_en_q   <= 1'b1;
                wr_addr_q <= addr_sh;
                wr_data_q <= {sdi_i, wdat_sh[DATA_W-1:1]};
            end
            if (state_d != ST_RDATA) begin
                drive_q <= 1'b0;
            end else if (fall) begin
                drive_q <= 1'b1;
                sdo_q   <= rdat_sh[0];
            end
        end
    end

    assign rd_addr_o = addr_sh;
    assign wr_en_o   = wr_en_q;
    assign wr_addr_o = wr_addr_q;
    assign wr_data_o = wr_data_q;
    assign sdo_o     = sdo_q;
    assign sdo_oe_o  = drive_q;
    assign rise_o    = rise;
    assign fall_o    = fall;

endmodule

// File: rtl/sreg_slave.sv
module sreg_slave #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);

    logic [2:0]        pins_s;
    logic              sel;
    logic              sclk_rise, sclk_fall;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    sreg_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n, sclk, sdi}),
        .q_o   (pins_s)
    );

    assign sel = ~pins_s[2];

    sreg_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel),
        .sclk_i    (pins_s[1]),
        .sdi_i     (pins_s[0]),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .sdo_o     (sdo),
        .sdo_oe_o  (sdo_oe),
        .rise_o    (sclk_rise),
        .fall_o    (sclk_fall)
    );

    sreg_bank #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .waddr_i (wr_addr),
        .wdata_i (wr_data),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

endmodule

// File: rtl/sreg_slave_chk.sv
module sreg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sel,
    input logic sclk_rise,
    input logic sclk_fall,
    input logic wr_en,
    input logic sdo,
    input logic sdo_oe
);

    AST_OE_DROPS_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !sdo_oe); // R7

    AST_COMMIT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(sclk_rise) && $past(sel))); // R3

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R3

    AST_SDO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && !$past(sclk_fall)) |-> $stable(sdo)); // R4

    AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(sclk_fall)); // R4

    always_comb begin
        if (rst_n == 1'b0) begin
            AST_RESET_QUIET: assert (!sdo_oe && !wr_en); // R9
        end
    end

endmodule

bind sreg_slave sreg_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .wr_en     (wr_en),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
);

// File: tb/sreg_slave_bench.sv
module sreg_slave_bench;

    localparam int HALF = 8;

    logic clk    = 1'b0;
    logic rst_n  = 1'b0;
    logic cs_n   = 1'b1;
    logic sclk   = 1'b0;
    logic sdi    = 1'b0;
    logic sdo;
    logic sdo_oe;

    int chk_cnt  = 0;
    int fail_cnt = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sreg_slave u_sreg_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .sdi    (sdi),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 91) & 255);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        chk_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drives one frame; stops before rising edge number nbits when nbits < 16.
    // live = 1 means the block is expected to answer (select low, out of reset).
    task automatic frame(input bit rd, input logic [6:0] a, input logic [7:0] wd,
                         input int nbits, input bit live, output logic [7:0] rv);
        rv = '0;
        for (int i = 0; i < 16; i++) begin
            bit b;
            bit exp_oe;
            if (i < 7)       b = a[i];
            else if (i == 7) b = rd;
            else             b = rd ? 1'b0 : wd[i-8];
            sdi = b;
            tick(HALF);
            if (i == nbits) return;
            exp_oe = live && rd && (i >= 8);
            check(sdo_oe == exp_oe, "R5", $sformatf("oe at bit %0d", i),
                  int'(sdo_oe), int'(exp_oe));
            if (rd && i >= 8) rv[i-8] = sdo;
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
    endtask

    initial begin
        logic [7:0] rv;
        tick(4);
        // R9: a read frame under reset must not drive the output.
        cs_n = 1'b0;
        frame(1'b1, 7'd3, 8'h00, 16, 1'b0, rv);
        cs_n = 1'b1;
        tick(4);
        rst_n = 1'b1;
        tick(6);
        check(sdo_oe == 1'b0, "R1", "oe after reset", int'(sdo_oe), 0);

        // R1: every register reads zero after reset (back-to-back reads, R6).
        cs_n = 1'b0;
        for (int a = 0; a < 128; a++) begin
            frame(1'b1, 7'(a), 8'h00, 16, 1'b1, rv);
            check(rv == 8'h00, "R1", $sformatf("reset value @%0d", a), int'(rv), 0);
        end
        cs_n = 1'b1;
        tick(6);

        // R2/R6: write the whole bank in one select.
        cs_n = 1'b0;
        for (int a = 0; a < 128; a++) frame(1'b0, 7'(a), pat(a), 16, 1'b1, rv);
        cs_n = 1'b1;
        tick(6);

        // R4/R6: read the whole bank back in one select.
        cs_n = 1'b0;
        for (int a = 0; a < 128; a++) begin
            frame(1'b1, 7'(a), 8'h00, 16, 1'b1, rv);
            check(rv == pat(a), "R4", $sformatf("readback @%0d", a), int'(rv), int'(pat(a)));
        end
        cs_n = 1'b1;
        tick(6);

        // R7/R3: write aborted after 15 rising edges leaves the register alone.
        cs_n = 1'b0;
        frame(1'b0, 7'd5, ~pat(5), 15, 1'b1, rv);
        cs_n = 1'b1;
        tick(6);
        check(sdo_oe == 1'b0, "R7", "oe after write abort", int'(sdo_oe), 0);
        cs_n = 1'b0;
        frame(1'b1, 7'd5, 8'h00, 16, 1'b1, rv);
        cs_n = 1'b1;
        check(rv == pat(5), "R3", "aborted write discarded", int'(rv), int'(pat(5)));
        tick(6);

        // R7: read aborted inside the data window releases the pad.
        cs_n = 1'b0;
        frame(1'b1, 7'd9, 8'h00, 11, 1'b1, rv);
        check(sdo_oe == 1'b1, "R5", "oe mid read window", int'(sdo_oe), 1);
        cs_n = 1'b1;
        tick(6);
        check(sdo_oe == 1'b0, "R7", "oe after read abort", int'(sdo_oe), 0);
        // R7: next frame is aligned from bit 0.
        cs_n = 1'b0;
        frame(1'b0, 7'd9, 8'h3C, 16, 1'b1, rv);
        frame(1'b1, 7'd9, 8'h00, 16, 1'b1, rv);
        cs_n = 1'b1;
        check(rv == 8'h3C, "R7", "frame alignment after abort", int'(rv), 'h3C);
        tick(6);

        // R8: a full write frame with select high is ignored.
        frame(1'b0, 7'd20, 8'hFF, 16, 1'b0, rv);
        tick(6);
        // R10: two reads in a row return the same value.
        cs_n = 1'b0;
        frame(1'b1, 7'd20, 8'h00, 16, 1'b1, rv);
        check(rv == pat(20), "R8", "write with select high ignored", int'(rv), int'(pat(20)));
        frame(1'b1, 7'd20, 8'h00, 16, 1'b1, rv);
        check(rv == pat(20), "R10", "read leaves register unchanged", int'(rv), int'(pat(20)));
        cs_n = 1'b1;
        tick(6);

        // R2: address bit order, A6 only versus A0 only.
        cs_n = 1'b0;
        frame(1'b0, 7'h40, 8'h81, 16, 1'b1, rv);
        frame(1'b1, 7'h01, 8'h00, 16, 1'b1, rv);
        check(rv == pat(1), "R2", "reg 0x01 untouched by 0x40 write", int'(rv), int'(pat(1)));
        frame(1'b1, 7'h40, 8'h00, 16, 1'b1, rv);
        check(rv == 8'h81, "R2", "reg 0x40 data order", int'(rv), 'h81);
        cs_n = 1'b1;
        tick(6);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            chk_cnt++;
            fail_cnt++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
            $finish;
        end
    end

endmodule